// File: doc/BRIEF.md
# Parallel SCSI Initiator Phase Sequencer

This block carries out one bus step at a time for the initiator side of a narrow parallel SCSI link. The host writes a one-byte command. The low nibble selects the action and the upper bits modify it. The block then runs that action against the target: a fixed-delay arbitration, a selection that waits for the target's BSY, a single-cycle housekeeping action, or a byte transfer in one of the six information phases. For each byte of a transfer it completes one REQ/ACK handshake, moving data between a 16-entry byte FIFO and the bus.

Each command ends with exactly one event pulse: command done, phase mismatch, or selection timeout. After a transfer the host reads the remaining byte count to see how much did not move. A transfer stops as soon as the target presents a phase that differs from the one the command expects. The block does not keep going blindly. A host that feeds the FIFO through an external mover can enable a request flag that tells it when the FIFO needs service.

Top module: `scsi_ini_seq`

## Requirements
- R1: The command opcode is `cmd_data[3:0]`. Codes 3 to 8 each expect one bus phase {MSG,C/D,I/O}: 3 expects 010, 4 expects 011, 5 expects 000, 6 expects 001, 7 expects 110 and 8 expects 111. When I/O is 0, bytes move from the FIFO to `bus_dout`. When I/O is 1, `bus_din` is pushed into the FIFO. Bytes move in FIFO order.
- R2: Each byte uses one handshake. ACK rises only after REQ has been seen high in the expected phase. ACK stays high until REQ is seen low and is then released. Only at that release does the count drop by one.
- R3: The 16-bit count is loaded one byte at a time (low, high) while the block is idle. A loaded value of 0 means 65536 bytes. `residual` always shows the bytes not yet transferred.
- R4: If REQ arrives with a phase other than the expected one, the command ends with a one-cycle `exc_phase` pulse and no `cmd_done`. No byte moves and the count is left as it was.
- R5: The FIFO holds 16 bytes. `fifo_level` shows its occupancy. A write to a full FIFO is dropped. Data leaves in the order it was written.
- R6: Opcode F empties the FIFO in the cycle it is accepted and signals done.
- R7: Command bit 5 asserts ATN. During a message-out transfer (opcode 7), ATN is low by the time ACK rises for the final byte, and it is high for every earlier byte.
- R8: Command bit 7 enables `dma_req` during a transfer. For an outbound phase it shows that the FIFO is not full, and for an inbound phase that the FIFO is not empty. Without bit 7 it stays low.
- R9: Opcode 1 completes with `cmd_done` a fixed ARB_CYCLES+1 cycles after the cycle in which it is accepted.
- R10: Opcode 2 drives `ini_sel`. It completes with done when BSY is seen. If no BSY has been seen after timeout×TMO_UNIT+1 cycles, it ends with `exc_seltmo` instead.
- R11: A command written while another one is running sets the sticky `seq_err` flag and is otherwise ignored. Opcode E clears `seq_err`, empties the FIFO and drops ATN.
- R12: Opcode 9 drops ATN and signals done. Opcodes 0 and A to D signal done with no further effect.
- R13: Every accepted command ends in exactly one of `cmd_done`, `exc_phase` or `exc_seltmo`. Each of these is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte: opcode and modifier bits |
| cnt_lo_wr | input | 1 | Write the low count byte |
| cnt_hi_wr | input | 1 | Write the high count byte |
| cnt_wdata | input | 8 | Count byte value |
| tmo_wr | input | 1 | Write the selection timeout |
| tmo_wdata | input | 8 | Selection timeout in TMO_UNIT-cycle units |
| fifo_wr | input | 1 | Host push into the FIFO |
| fifo_wdata | input | 8 | Host push data |
| fifo_rd | input | 1 | Host pop from the FIFO |
| fifo_rdata | output | 8 | Byte at the FIFO head |
| fifo_level | output | 5 | FIFO occupancy |
| residual | output | 16 | Bytes remaining in the current or last transfer |
| busy | output | 1 | A command is running |
| cmd_done | output | 1 | Command completed (pulse) |
| exc_phase | output | 1 | Phase mismatch (pulse) |
| exc_seltmo | output | 1 | Selection timeout (pulse) |
| seq_err | output | 1 | Sticky flag for a command written while busy |
| dma_req | output | 1 | FIFO service request |
| tgt_req | input | 1 | REQ from the target |
| tgt_msg | input | 1 | MSG phase line |
| tgt_cd | input | 1 | C/D phase line |
| tgt_io | input | 1 | I/O phase line |
| tgt_bsy | input | 1 | BSY from the target |
| bus_din | input | 8 | Data from the bus |
| bus_dout | output | 8 | Data driven to the bus |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| ini_ack | output | 1 | ACK to the target |
| ini_atn | output | 1 | ATN to the target |
| ini_sel | output | 1 | SEL to the target |

## Verification
The embedded assertions check these properties on every cycle:
- ACK never rises without REQ having been seen.
- ATN is low whenever ACK is high on the last message-out byte.
- The count only ever steps down by one, at an ACK release.
- A mismatch leaves the count untouched.
- The three end events never coincide.
- The FIFO never exceeds its depth and is empty right after a flush.
- The timeout counter never passes its limit.

The bench scenarios show what no single-cycle property can:
- the byte values and their order across every transfer phase and several lengths;
- the 65536-byte meaning of a zero count;
- the exact arbitration and timeout latencies;
- that a command written while busy really leaves the FIFO alone.

// File: rtl/sis_pkg.sv
package sis_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARB   = 3'd1,
    ST_SEL   = 3'd2,
    ST_XWAIT = 3'd3,
    ST_XACK  = 3'd4
  } seq_state_e;

  localparam logic [3:0] OP_ARB   = 4'h1;
  localparam logic [3:0] OP_SEL   = 4'h2;
  localparam logic [3:0] OP_MOUT  = 4'h7;
  localparam logic [3:0] OP_FREE  = 4'h9;
  localparam logic [3:0] OP_RESET = 4'hE;
  localparam logic [3:0] OP_FLUSH = 4'hF;

  localparam int MOD_DMA_BIT = 7;
  localparam int MOD_ATN_BIT = 5;

  function automatic logic op_is_xfer(input logic [3:0] op);
    return (op >= 4'h3) && (op <= 4'h8);
  endfunction

  // expected {MSG, C/D, I/O} for each transfer opcode
  function automatic logic [2:0] op_phase(input logic [3:0] op);
    case (op)
      4'h3:    return 3'b010;
      4'h4:    return 3'b011;
      4'h5:    return 3'b000;
      4'h6:    return 3'b001;
      4'h7:    return 3'b110;
      4'h8:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/sis_fifo.sv
module sis_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem[rd_q];
  assign level   = lvl_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (push_ok) wr_d = bump(wr_q);
      if (pop_ok)  rd_d = bump(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

  assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lvl_q == '0));

endmodule

// File: rtl/sis_timer.sv
module sis_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == limit);

  always_comb begin
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_timer_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

endmodule

// File: rtl/sis_ctrl.sv
module sis_ctrl
  import sis_pkg::*;
#(
  parameter int TMO_UNIT   = 4,
  parameter int ARB_CYCLES = 6,
  parameter int TW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_data,
  input  logic          cnt_lo_wr,
  input  logic          cnt_hi_wr,
  input  logic [7:0]    cnt_wdata,
  input  logic          tmo_wr,
  input  logic [7:0]    tmo_wdata,
  input  logic          tgt_req,
  input  logic [2:0]    tgt_phase,
  input  logic          tgt_bsy,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  input  logic [7:0]    fifo_head,
  input  logic          tmr_expired,
  output logic          busy,
  output logic          ack,
  output logic          atn,
  output logic          sel,
  output logic [15:0]   count,
  output logic [7:0]    dout,
  output logic          oe,
  output logic          done,
  output logic          exc_phase,
  output logic          exc_seltmo,
  output logic          seq_err,
  output logic          dma_req,
  output logic          eng_push,
  output logic          eng_pop,
  output logic          fifo_flush,
  output logic          tmr_run,
  output logic [TW-1:0] tmr_limit
);

  seq_state_e  state_q, state_d;
  logic [3:0]  op_q, op_d;
  logic        dma_q, dma_d;
  logic [15:0] cnt_q, cnt_d;
  logic [7:0]  tmo_q, tmo_d;
  logic        atn_q, atn_d, ack_q, ack_d;
  logic        done_q, done_d, excp_q, excp_d, excs_q, excs_d;
  logic        serr_q, serr_d;
  logic [7:0]  dout_q, dout_d;
  logic        out_dir, in_xfer;
  logic        unused_mod;

  assign unused_mod = ^{cmd_data[6], cmd_data[4]};
  assign out_dir    = !op_phase(op_q)[0];
  assign in_xfer    = (state_q == ST_XWAIT) || (state_q == ST_XACK);

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    dma_d      = dma_q;
    cnt_d      = cnt_q;
    tmo_d      = tmo_q;
    atn_d      = atn_q;
    ack_d      = ack_q;
    serr_d     = serr_q;
    dout_d     = dout_q;
    done_d     = 1'b0;
    excp_d     = 1'b0;
    excs_d     = 1'b0;
    eng_push   = 1'b0;
    eng_pop    = 1'b0;
    fifo_flush = 1'b0;
    if (cmd_wr && state_q != ST_IDLE) serr_d = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (cnt_lo_wr) cnt_d[7:0]  = cnt_wdata;
        if (cnt_hi_wr) cnt_d[15:8] = cnt_wdata;
        if (tmo_wr)    tmo_d       = tmo_wdata;
        if (cmd_wr) begin
          op_d  = cmd_data[3:0];
          dma_d = cmd_data[MOD_DMA_BIT];
          if (cmd_data[MOD_ATN_BIT]) atn_d = 1'b1;
          if (cmd_data[3:0] == OP_ARB) begin
            state_d = ST_ARB;
          end else if (cmd_data[3:0] == OP_SEL) begin
            state_d = ST_SEL;
          end else if (op_is_xfer(cmd_data[3:0])) begin
            state_d = ST_XWAIT;
          end else begin
            done_d = 1'b1;
            case (cmd_data[3:0])
              OP_FREE:  atn_d = 1'b0;
              OP_FLUSH: fifo_flush = 1'b1;
              OP_RESET: begin
                fifo_flush = 1'b1;
                serr_d     = 1'b0;
                atn_d      = 1'b0;
              end
              default: ;
            endcase
          end
        end
      end
      ST_ARB: begin
        if (tmr_expired) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_SEL: begin
        if (tgt_bsy) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_expired) begin
          excs_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_XWAIT: begin
        if (op_q == OP_MOUT && cnt_q == 16'd1) atn_d = 1'b0;
        if (tgt_req) begin
          if (tgt_phase != op_phase(op_q)) begin
            excp_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (out_dir && !fifo_empty) begin
            eng_pop = 1'b1;
            dout_d  = fifo_head;
            ack_d   = 1'b1;
            state_d = ST_XACK;
          end else if (!out_dir && !fifo_full) begin
            eng_push = 1'b1;
            ack_d    = 1'b1;
            state_d  = ST_XACK;
          end
        end
      end
      ST_XACK: begin
        if (!tgt_req) begin
          ack_d = 1'b0;
          cnt_d = cnt_q - 16'd1;
          if (cnt_q == 16'd1) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_XWAIT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      dma_q   <= 1'b0;
      cnt_q   <= '0;
      tmo_q   <= '0;
      atn_q   <= 1'b0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      excp_q  <= 1'b0;
      excs_q  <= 1'b0;
      serr_q  <= 1'b0;
      dout_q  <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      dma_q   <= dma_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
      atn_q   <= atn_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
      excp_q  <= excp_d;
      excs_q  <= excs_d;
      serr_q  <= serr_d;
      dout_q  <= dout_d;
    end
  end

  assign tmr_run   = (state_q == ST_ARB) || (state_q == ST_SEL);
  assign tmr_limit = (state_q == ST_SEL) ? TW'(tmo_q) * TW'(TMO_UNIT) : TW'(ARB_CYCLES);

  assign busy       = (state_q != ST_IDLE);
  assign ack        = ack_q;
  assign atn        = atn_q;
  assign sel        = (state_q == ST_SEL);
  assign count      = cnt_q;
  assign dout       = dout_q;
  assign oe         = in_xfer && out_dir;
  assign done       = done_q;
  assign exc_phase  = excp_q;
  assign exc_seltmo = excs_q;
  assign seq_err    = serr_q;
  assign dma_req    = dma_q && in_xfer && (out_dir ? !fifo_full : !fifo_empty);

  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(tgt_req));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cnt_q) && $past(state_q) != ST_IDLE) |-> (cnt_q == $past(cnt_q) - 16'd1));

  assert_mismatch_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    excp_q |-> ($stable(cnt_q) && $past(tgt_req)));

  assert_atn_last_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && op_q == OP_MOUT && cnt_q == 16'd1) |-> !atn_q);

  assert_busy_write_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && state_q != ST_IDLE) |=> serr_q);

  assert_single_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, excp_q, excs_q}));

endmodule

// File: rtl/scsi_ini_seq.sv
module scsi_ini_seq
  import sis_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TMO_UNIT   = 4,
  parameter int ARB_CYCLES = 6,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_data,
  input  logic          cnt_lo_wr,
  input  logic          cnt_hi_wr,
  input  logic [7:0]    cnt_wdata,
  input  logic          tmo_wr,
  input  logic [7:0]    tmo_wdata,
  input  logic          fifo_wr,
  input  logic [7:0]    fifo_wdata,
  input  logic          fifo_rd,
  output logic [7:0]    fifo_rdata,
  output logic [LW-1:0] fifo_level,
  output logic [15:0]   residual,
  output logic          busy,
  output logic          cmd_done,
  output logic          exc_phase,
  output logic          exc_seltmo,
  output logic          seq_err,
  output logic          dma_req,
  input  logic          tgt_req,
  input  logic          tgt_msg,
  input  logic          tgt_cd,
  input  logic          tgt_io,
  input  logic          tgt_bsy,
  input  logic [7:0]    bus_din,
  output logic [7:0]    bus_dout,
  output logic          bus_oe,
  output logic          ini_ack,
  output logic          ini_atn,
  output logic          ini_sel
);

  localparam int TW = $clog2(255 * TMO_UNIT + ARB_CYCLES + 1) + 1;

  logic          f_full, f_empty, f_flush, f_push, f_pop;
  logic [7:0]    f_wdata;
  logic          eng_push, eng_pop;
  logic          tmr_run, tmr_exp;
  logic [TW-1:0] tmr_limit;

  assign f_push  = eng_push || fifo_wr;
  assign f_wdata = eng_push ? bus_din : fifo_wdata;
  assign f_pop   = eng_pop || fifo_rd;

  sis_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (f_flush),
    .push  (f_push),
    .wdata (f_wdata),
    .pop   (f_pop),
    .rdata (fifo_rdata),
    .level (fifo_level),
    .full  (f_full),
    .empty (f_empty)
  );

  sis_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_run),
    .limit   (tmr_limit),
    .expired (tmr_exp)
  );

  sis_ctrl #(.TMO_UNIT(TMO_UNIT), .ARB_CYCLES(ARB_CYCLES), .TW(TW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_data    (cmd_data),
    .cnt_lo_wr   (cnt_lo_wr),
    .cnt_hi_wr   (cnt_hi_wr),
    .cnt_wdata   (cnt_wdata),
    .tmo_wr      (tmo_wr),
    .tmo_wdata   (tmo_wdata),
    .tgt_req     (tgt_req),
    .tgt_phase   ({tgt_msg, tgt_cd, tgt_io}),
    .tgt_bsy     (tgt_bsy),
    .fifo_full   (f_full),
    .fifo_empty  (f_empty),
    .fifo_head   (fifo_rdata),
    .tmr_expired (tmr_exp),
    .busy        (busy),
    .ack         (ini_ack),
    .atn         (ini_atn),
    .sel         (ini_sel),
    .count       (residual),
    .dout        (bus_dout),
    .oe          (bus_oe),
    .done        (cmd_done),
    .exc_phase   (exc_phase),
    .exc_seltmo  (exc_seltmo),
    .seq_err     (seq_err),
    .dma_req     (dma_req),
    .eng_push    (eng_push),
    .eng_pop     (eng_pop),
    .fifo_flush  (f_flush),
    .tmr_run     (tmr_run),
    .tmr_limit   (tmr_limit)
  );

endmodule

// File: tb/scsi_ini_seq_tb.sv
module scsi_ini_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ARB        = 6;
  localparam int UNIT       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0, cnt_lo_wr = 1'b0, cnt_hi_wr = 1'b0, tmo_wr = 1'b0;
  logic [7:0] cmd_data = '0, cnt_wdata = '0, tmo_wdata = '0;
  logic       fifo_wr = 1'b0, fifo_rd = 1'b0;
  logic [7:0] fifo_wdata = '0, fifo_rdata;
  logic [4:0] fifo_level;
  logic [15:0] residual;
  logic       busy, cmd_done, exc_phase, exc_seltmo, seq_err, dma_req;
  logic       tgt_req = 1'b0, tgt_msg = 1'b0, tgt_cd = 1'b0, tgt_io = 1'b0, tgt_bsy = 1'b0;
  logic [7:0] bus_din = '0, bus_dout;
  logic       bus_oe, ini_ack, ini_atn, ini_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  scsi_ini_seq #(.FIFO_DEPTH(16), .TMO_UNIT(UNIT), .ARB_CYCLES(ARB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .cnt_lo_wr(cnt_lo_wr), .cnt_hi_wr(cnt_hi_wr), .cnt_wdata(cnt_wdata),
    .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata), .fifo_level(fifo_level),
    .residual(residual), .busy(busy), .cmd_done(cmd_done), .exc_phase(exc_phase),
    .exc_seltmo(exc_seltmo), .seq_err(seq_err), .dma_req(dma_req),
    .tgt_req(tgt_req), .tgt_msg(tgt_msg), .tgt_cd(tgt_cd), .tgt_io(tgt_io),
    .tgt_bsy(tgt_bsy), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .ini_ack(ini_ack), .ini_atn(ini_atn), .ini_sel(ini_sel)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [2:0] want(input int op);
    case (op)
      3: return 3'b010;
      4: return 3'b011;
      5: return 3'b000;
      6: return 3'b001;
      7: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic host_cmd(input logic [7:0] v);
    cmd_data = v; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic host_cnt(input int c);
    cnt_wdata = c[7:0]; cnt_lo_wr = 1'b1;
    @(negedge clk);
    cnt_lo_wr = 1'b0; cnt_wdata = c[15:8]; cnt_hi_wr = 1'b1;
    @(negedge clk);
    cnt_hi_wr = 1'b0;
  endtask

  task automatic host_tmo(input int t);
    tmo_wdata = t[7:0]; tmo_wr = 1'b1;
    @(negedge clk);
    tmo_wr = 1'b0;
  endtask

  task automatic host_push(input logic [7:0] d);
    fifo_wdata = d; fifo_wr = 1'b1;
    @(negedge clk);
    fifo_wr = 1'b0;
  endtask

  task automatic host_pop(output logic [7:0] d);
    d = fifo_rdata; fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  task automatic tgt_byte(input logic [2:0] ph, input logic [7:0] din,
                          output logic [7:0] dout, output logic atn_seen);
    {tgt_msg, tgt_cd, tgt_io} = ph;
    bus_din = din;
    chk("R2 ack low before req", int'(ini_ack), 0);
    tgt_req = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ini_ack) break;
    end
    chk("R2 ack after req", int'(ini_ack), 1);
    dout = bus_dout;
    atn_seen = ini_atn;
    tgt_req = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!ini_ack) break;
    end
  endtask

  task automatic wait_end(output int n, output logic d, output logic ep, output logic es);
    n = 1;
    for (int k = 0; k < 3000; k++) begin
      if (cmd_done || exc_phase || exc_seltmo) break;
      @(negedge clk);
      n++;
    end
    d = cmd_done; ep = exc_phase; es = exc_seltmo;
  endtask

  initial begin
    int n;
    logic d, ep, es, atn_seen;
    logic [7:0] bd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R13 reset busy", int'(busy), 0);
    chk("R7 reset atn", int'(ini_atn), 0);
    chk("R5 reset level", int'(fifo_level), 0);
    chk("R3 reset residual", int'(residual), 0);
    chk("R11 reset seq_err", int'(seq_err), 0);

    // FIFO fill sweep with flush between fills
    for (int fill = 0; fill <= 18; fill++) begin
      host_cmd(8'h0F);
      wait_end(n, d, ep, es);
      chk("R6 flush done", int'(d), 1);
      chk("R6 flush empties", int'(fifo_level), 0);
      for (int i = 0; i < fill; i++) host_push(8'(i + 1));
      chk("R5 level", int'(fifo_level), (fill > 16) ? 16 : fill);
    end
    for (int i = 0; i < 16; i++) begin
      host_pop(bd);
      chk("R5 order", int'(bd), i + 1);
    end

    // transfer sweep: every phase, lengths 1..4
    for (int op = 3; op <= 8; op++) begin
      for (int c = 1; c <= 4; c++) begin
        automatic bit outd = (op == 3) || (op == 5) || (op == 7);
        automatic bit udma = (c == 2);
        automatic bit uatn = (op == 7);
        host_cnt(c);
        if (outd) for (int i = 0; i < c; i++) host_push(8'(op * 16 + i * 3));
        host_cmd({udma, 1'b0, uatn, 1'b0, 4'(op)});
        chk("R8 dma_req at start", int'(dma_req), int'(udma && outd));
        for (int i = 0; i < c; i++) begin
          tgt_byte(want(op), 8'(8'h40 + op * 8 + i), bd, atn_seen);
          if (outd) chk("R1 outbound byte", int'(bd), op * 16 + i * 3);
          chk("R7 atn at ack", int'(atn_seen), int'(uatn && (i != c - 1)));
          if (udma && i == 0) chk("R8 dma_req mid", int'(dma_req), 1);
        end
        wait_end(n, d, ep, es);
        chk("R1 transfer done", int'(d), 1);
        chk("R13 no exception", int'(ep | es), 0);
        chk("R3 residual zero", int'(residual), 0);
        if (!udma) chk("R8 dma_req off", int'(dma_req), 0);
        if (!outd) begin
          for (int i = 0; i < c; i++) begin
            host_pop(bd);
            chk("R1 inbound byte", int'(bd), 8'h40 + op * 8 + i);
          end
        end
      end
    end

    // phase mismatch on the first byte for every transfer opcode
    for (int op = 3; op <= 8; op++) begin
      host_cnt(5);
      host_cmd(8'(op));
      {tgt_msg, tgt_cd, tgt_io} = want(op) ^ 3'b100;
      tgt_req = 1'b1;
      @(negedge clk);
      chk("R4 exc_phase", int'(exc_phase), 1);
      chk("R4 no done", int'(cmd_done), 0);
      chk("R4 idle after", int'(busy), 0);
      chk("R4 residual kept", int'(residual), 5);
      chk("R4 ack stays low", int'(ini_ack), 0);
      tgt_req = 1'b0;
      @(negedge clk);
      chk("R13 event one cycle", int'(exc_phase), 0);
    end

    // zero count = 65536: move 10 bytes, then stop by mismatch
    host_cnt(0);
    host_cmd(8'h06);
    for (int i = 0; i < 10; i++) tgt_byte(3'b001, 8'(i), bd, atn_seen);
    chk("R3 still busy", int'(busy), 1);
    chk("R3 residual after 10", int'(residual), 65536 - 10);
    {tgt_msg, tgt_cd, tgt_io} = 3'b011;
    tgt_req = 1'b1;
    @(negedge clk);
    chk("R4 exc after data", int'(exc_phase), 1);
    chk("R3 residual held", int'(residual), 65526);
    tgt_req = 1'b0;
    host_cmd(8'h0F);
    wait_end(n, d, ep, es);

    // arbitration latency
    host_cmd(8'h01);
    wait_end(n, d, ep, es);
    chk("R9 arb done", int'(d), 1);
    chk("R9 arb latency", n, ARB + 2);
    @(negedge clk);
    chk("R13 done one cycle", int'(cmd_done), 0);

    // selection timeout sweep
    foreach (n_tmo_list[j]) begin
      host_tmo(n_tmo_list[j]);
      host_cmd(8'h02);
      chk("R10 sel driven", int'(ini_sel), 1);
      wait_end(n, d, ep, es);
      chk("R10 timeout event", int'(es), 1);
      chk("R10 no done", int'(d), 0);
      chk("R10 timeout latency", n, n_tmo_list[j] * UNIT + 2);
    end

    // selection answered, with ATN, then bus free
    host_tmo(50);
    host_cmd(8'h22);
    chk("R10 sel high", int'(ini_sel), 1);
    chk("R7 atn from modifier", int'(ini_atn), 1);
    tgt_bsy = 1'b1;
    wait_end(n, d, ep, es);
    chk("R10 sel done on bsy", int'(d), 1);
    chk("R10 no timeout", int'(es), 0);
    tgt_bsy = 1'b0;
    @(negedge clk);
    chk("R10 sel released", int'(ini_sel), 0);
    host_cmd(8'h09);
    chk("R12 bus free done", int'(cmd_done), 1);
    chk("R12 atn dropped", int'(ini_atn), 0);
    host_cmd(8'h0B);
    chk("R12 parity cmd done", int'(cmd_done), 1);

    // command while busy is flagged and ignored
    host_cnt(1);
    host_cmd(8'h06);
    host_cmd(8'h0F);
    chk("R11 seq_err set", int'(seq_err), 1);
    chk("R11 still busy", int'(busy), 1);
    tgt_byte(3'b001, 8'h5A, bd, atn_seen);
    wait_end(n, d, ep, es);
    chk("R11 transfer completes", int'(d), 1);
    chk("R11 flush was ignored", int'(fifo_level), 1);
    host_cmd(8'h0E);
    chk("R11 reset clears seq_err", int'(seq_err), 0);
    chk("R11 reset empties fifo", int'(fifo_level), 0);
    chk("R11 reset done", int'(cmd_done), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int n_tmo_list [4] = '{0, 1, 3, 7};

endmodule